// File: doc/BRIEF.md
# Programmable Clock Rate Divider

The block divides its single input clock by an integer ratio chosen through a small register interface. Software writes a control word. The block takes a divider code from a parameterised bit offset in that word and turns it into a divisor. Each instance uses one of four encodings, fixed at build time: code plus one, the code taken directly, two to the power of the code, or a lookup in a table where a zero entry marks a forbidden code. The output clock is never gated. Its period is always an exact multiple of the input period.

A write whose code does not give a legal divisor is refused. The old divisor stays in force and a sticky error flag is raised. An instance can optionally require an explicit commit bit before a staged code reaches the counter. An optional automatic-idle enable, with selectable polarity, is taken from its own bit of the control word. A new divisor is applied only at the end of the output period that is running, so the output never shows a shortened phase.

Top module: `clk_rate_div`

## Requirements
- R1: In plus-one encoding, the output period in input cycles equals the code plus one (code 0 gives 1, code 2 gives 3).
- R2: In direct encoding, the period equals the code, and code 0 is refused as illegal.
- R3: In power-of-two encoding, the period equals 2 raised to the code (codes 0, 1, 2 give 1, 2, 4).
- R4: In table encoding, the period equals the table entry that the code indexes, and a code whose entry is zero is refused.
- R5: Outside table encoding, a decoded divisor below MIN_DIV or above MAX_DIV is refused, and the active divisor always stays inside those bounds.
- R6: A refused write leaves the output period and the code read back from control (address 0) unchanged. It sets status bit 0 (address 1), which stays set until a write of 1 to status bit 0 clears it.
- R7: With the commit option on, a legal code write without the commit bit (LATCH_BIT) leaves the period unchanged and sets status bit 1 (pending). A control write with the commit bit set applies the staged code and clears pending. The commit bit always reads back as 0.
- R8: A divisor change takes effect at the first period boundary after the write. The period that is running at the time of the write completes at its old length.
- R9: With automatic idle on, autoidle_o equals control bit IDLE_BIT XOR IDLE_INV from the cycle after the write. After reset it is 0.
- R10: For a divisor N of 2 or more, the output is high for floor(N/2) input cycles and low for the rest of the period. For N = 1 the output follows the input clock.
- R11: The code is taken from bits FIELD_LSB upward. Other control bits have no effect on the period and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, also clocks the register interface |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data of the selected register |
| clk_div_o | output | 1 | Divided output clock |
| autoidle_o | output | 1 | Automatic-idle enable |

## Verification
On every cycle, the bound checker confirms four things: the active divisor stays legal, it changes only at a period boundary, the error flag is sticky, and the idle output tracks the written bit. It also confirms that an uncommitted write never moves the target divisor. The bench drives four instances, one per encoding, with different field offsets and options. For every legal code, the scenarios measure the real output period and high time, and they compare the boundary period with the old divisor. They also show that refused codes and uncommitted writes leave the measured period unchanged.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int DIV_W   = 8;
  localparam int TBL_LEN = 16;
  localparam int TBL_W   = TBL_LEN * DIV_W;

  typedef enum logic [1:0] {ENC_PLUS1, ENC_DIRECT, ENC_POW2, ENC_TABLE} enc_e;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
  } dec_t;

  function automatic dec_t decode_code(enc_e enc, int unsigned code,
                                       logic [TBL_W-1:0] tbl,
                                       int unsigned min_div, int unsigned max_div);
    int unsigned d;
    dec_t        r;
    case (enc)
      ENC_PLUS1:  d = code + 1;
      ENC_DIRECT: d = code;
      ENC_POW2:   d = (code < DIV_W) ? (32'd1 << code) : 32'd0;
      default:    d = (code < TBL_LEN) ? 32'(tbl[code*DIV_W +: DIV_W]) : 32'd0;
    endcase
    r.ok  = (d != 0) && (d < (32'd1 << DIV_W)) &&
            ((enc == ENC_TABLE) || ((d >= min_div) && (d <= max_div)));
    r.div = DIV_W'(d);
    return r;
  endfunction
endpackage

// File: rtl/crd_decode.sv
module crd_decode
  import crd_pkg::*;
#(
  parameter enc_e             ENC     = ENC_PLUS1,
  parameter int               FIELD_W = 4,
  parameter int unsigned      MIN_DIV = 1,
  parameter int unsigned      MAX_DIV = 16,
  parameter logic [TBL_W-1:0] DIV_TBL = '0
) (
  input  logic [FIELD_W-1:0] code_i,
  output logic               ok_o,
  output logic [DIV_W-1:0]   div_o
);
  dec_t dec;

  always_comb begin
    dec   = decode_code(ENC, 32'(code_i), DIV_TBL, MIN_DIV, MAX_DIV);
    ok_o  = dec.ok;
    div_o = dec.div;
  end
endmodule

// File: rtl/crd_regs.sv
module crd_regs
  import crd_pkg::*;
#(
  parameter int             REG_W     = 32,
  parameter int             FIELD_LSB = 0,
  parameter int             FIELD_W   = 4,
  parameter bit             LATCH_EN  = 1'b0,
  parameter int             LATCH_BIT = 31,
  parameter logic [REG_W-1:0] RST_CTRL = '0,
  parameter logic [DIV_W-1:0] RST_DIV  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             dec_ok_i,
  input  logic [DIV_W-1:0] dec_div_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic [DIV_W-1:0] tgt_div_o,
  output logic             err_o
);
  localparam logic [REG_W-1:0] FMASK = ((REG_W'(1) << FIELD_W) - 1'b1) << FIELD_LSB;
  localparam logic [REG_W-1:0] LMASK = LATCH_EN ? (REG_W'(1) << LATCH_BIT) : '0;

  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0] staged_q, tgt_q;
  logic             err_q;
  logic             wr_ctrl, wr_stat, commit, pending;

  assign wr_ctrl = wr_i && !addr_i;
  assign wr_stat = wr_i && addr_i;
  assign commit  = LATCH_EN && wdata_i[LATCH_BIT];
  assign pending = LATCH_EN && (staged_q != tgt_q);

  // refused codes keep the old field; commit bit never stored
  always_comb begin
    ctrl_d = wdata_i & ~LMASK;
    if (!dec_ok_i) ctrl_d = (ctrl_d & ~FMASK) | (ctrl_q & FMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= RST_CTRL;
      staged_q <= RST_DIV;
      tgt_q    <= RST_DIV;
      err_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_d;
        if (dec_ok_i) staged_q <= dec_div_i;
        else          err_q    <= 1'b1;
        if (LATCH_EN) begin
          if (commit) tgt_q <= dec_ok_i ? dec_div_i : staged_q;
        end else if (dec_ok_i) begin
          tgt_q <= dec_div_i;
        end
      end
      if (wr_stat && wdata_i[0]) err_q <= 1'b0;
    end
  end

  assign rdata_o   = addr_i ? {{(REG_W-2){1'b0}}, pending, err_q} : ctrl_q;
  assign ctrl_o    = ctrl_q;
  assign tgt_div_o = tgt_q;
  assign err_o     = err_q;
endmodule

// File: rtl/crd_gen.sv
module crd_gen
  import crd_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] tgt_div_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             period_end_o,
  output logic             clk_div_o
);
  logic [DIV_W-1:0] cnt_q, act_q;
  logic             q_q, at_end;

  assign at_end = (cnt_q == act_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RST_DIV;
      q_q   <= (RST_DIV > 1);
    end else if (at_end) begin
      cnt_q <= '0;
      act_q <= tgt_div_i;
      q_q   <= (tgt_div_i > 1);
    end else begin
      cnt_q <= cnt_q + 1'b1;
      q_q   <= ((cnt_q + 1'b1) < (act_q >> 1));
    end
  end

  // divide-by-one has no registered form: pass the input through
  assign clk_div_o    = (act_q == 1) ? clk_i : q_q;
  assign act_div_o    = act_q;
  assign period_end_o = at_end;
endmodule

// File: rtl/clk_rate_div.sv
module clk_rate_div
  import crd_pkg::*;
#(
  parameter int               REG_W     = 32,
  parameter enc_e             ENC       = ENC_PLUS1,
  parameter int               FIELD_LSB = 0,
  parameter int               FIELD_W   = 4,
  parameter int unsigned      MIN_DIV   = 1,
  parameter int unsigned      MAX_DIV   = 16,
  parameter logic [TBL_W-1:0] DIV_TBL   = '0,
  parameter int               RST_FIELD = 0,
  parameter bit               LATCH_EN  = 1'b0,
  parameter int               LATCH_BIT = 31,
  parameter bit               IDLE_EN   = 1'b0,
  parameter int               IDLE_BIT  = 30,
  parameter bit               IDLE_INV  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             clk_div_o,
  output logic             autoidle_o
);
  localparam dec_t RST_DEC = decode_code(ENC, RST_FIELD, DIV_TBL, MIN_DIV, MAX_DIV);
  localparam logic [DIV_W-1:0] RST_DIV = RST_DEC.div;
  localparam logic [REG_W-1:0] RST_CTRL =
    (REG_W'(RST_FIELD) << FIELD_LSB) | (REG_W'(IDLE_EN && IDLE_INV) << IDLE_BIT);

  logic             dec_ok, period_end, err_flag;
  logic [DIV_W-1:0] dec_div, tgt_div, act_div;
  logic [REG_W-1:0] ctrl;

  crd_decode #(
    .ENC(ENC), .FIELD_W(FIELD_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_TBL(DIV_TBL)
  ) u_dec (
    .code_i(reg_wdata_i[FIELD_LSB +: FIELD_W]),
    .ok_o  (dec_ok),
    .div_o (dec_div)
  );

  crd_regs #(
    .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .LATCH_EN(LATCH_EN),
    .LATCH_BIT(LATCH_BIT), .RST_CTRL(RST_CTRL), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .dec_ok_i (dec_ok),
    .dec_div_i(dec_div),
    .rdata_o  (reg_rdata_o),
    .ctrl_o   (ctrl),
    .tgt_div_o(tgt_div),
    .err_o    (err_flag)
  );

  crd_gen #(.RST_DIV(RST_DIV)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tgt_div_i   (tgt_div),
    .act_div_o   (act_div),
    .period_end_o(period_end),
    .clk_div_o   (clk_div_o)
  );

  if (IDLE_EN) begin : g_idle
    assign autoidle_o = ctrl[IDLE_BIT] ^ IDLE_INV;
  end else begin : g_no_idle
    assign autoidle_o = 1'b0;
  end
endmodule

// File: rtl/crd_checker.sv
module crd_checker
  import crd_pkg::*;
#(
  parameter int          REG_W     = 32,
  parameter enc_e        ENC       = ENC_PLUS1,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 16,
  parameter bit          LATCH_EN  = 1'b0,
  parameter int          LATCH_BIT = 31,
  parameter bit          IDLE_EN   = 1'b0,
  parameter int          IDLE_BIT  = 30,
  parameter bit          IDLE_INV  = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic             autoidle_i,
  input logic [DIV_W-1:0] act_div_i,
  input logic [DIV_W-1:0] tgt_div_i,
  input logic             period_end_i,
  input logic             err_i
);
  AST_ACT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div_i != 0) && ((ENC == ENC_TABLE) || ((act_div_i >= MIN_DIV) && (act_div_i <= MAX_DIV)))); // R5

  AST_SWITCH_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div_i != $past(act_div_i)) |-> $past(period_end_i)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(wr_i && addr_i && wdata_i[0])) |=> err_i); // R6

  AST_UNCOMMITTED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LATCH_EN && wr_i && !addr_i && !wdata_i[LATCH_BIT]) |=> $stable(tgt_div_i)); // R7

  AST_IDLE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IDLE_EN && wr_i && !addr_i) |=> (autoidle_i == ($past(wdata_i[IDLE_BIT]) ^ IDLE_INV))); // R9
endmodule

bind clk_rate_div crd_checker #(
  .REG_W(REG_W), .ENC(ENC), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .LATCH_EN(LATCH_EN),
  .LATCH_BIT(LATCH_BIT), .IDLE_EN(IDLE_EN), .IDLE_BIT(IDLE_BIT), .IDLE_INV(IDLE_INV)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (reg_wr_i),
  .addr_i      (reg_addr_i),
  .wdata_i     (reg_wdata_i),
  .autoidle_i  (autoidle_o),
  .act_div_i   (act_div),
  .tgt_div_i   (tgt_div),
  .period_end_i(period_end),
  .err_i       (err_flag)
);

// File: tb/tb_clk_rate_div.sv
module tb_clk_rate_div;
  import crd_pkg::*;

  localparam logic [TBL_W-1:0] TBL =
    {64'h0, 8'd9, 8'd1, 8'd6, 8'd0, 8'd2, 8'd5, 8'd0, 8'd3};

  typedef struct {
    int    u;
    int    prev;
    int    div;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr [4];
  logic        addr [4];
  logic [31:0] wd [4];
  logic [31:0] rd [4];
  logic        dclk [4];
  logic        idle [4];

  int total = 0, bad = 0, cyc = 0;
  int last_rise [4];
  int per [4];
  int hi [4];
  int rises [4];
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  clk_rate_div #(.ENC(ENC_PLUS1), .FIELD_LSB(0), .FIELD_W(4), .MAX_DIV(12),
    .IDLE_EN(1'b1), .IDLE_BIT(31), .IDLE_INV(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr[0]), .reg_addr_i(addr[0]),
    .reg_wdata_i(wd[0]), .reg_rdata_o(rd[0]), .clk_div_o(dclk[0]), .autoidle_o(idle[0]));

  clk_rate_div #(.ENC(ENC_DIRECT), .FIELD_LSB(8), .FIELD_W(3), .MAX_DIV(7), .RST_FIELD(1),
    .LATCH_EN(1'b1), .LATCH_BIT(16), .IDLE_EN(1'b1), .IDLE_BIT(5), .IDLE_INV(1'b1)) dut_dir (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr[1]), .reg_addr_i(addr[1]),
    .reg_wdata_i(wd[1]), .reg_rdata_o(rd[1]), .clk_div_o(dclk[1]), .autoidle_o(idle[1]));

  clk_rate_div #(.ENC(ENC_POW2), .FIELD_LSB(24), .FIELD_W(3), .MAX_DIV(16)) dut_p2 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr[2]), .reg_addr_i(addr[2]),
    .reg_wdata_i(wd[2]), .reg_rdata_o(rd[2]), .clk_div_o(dclk[2]), .autoidle_o(idle[2]));

  clk_rate_div #(.ENC(ENC_TABLE), .FIELD_LSB(4), .FIELD_W(3), .DIV_TBL(TBL),
    .LATCH_EN(1'b1), .LATCH_BIT(31)) dut_tbl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr[3]), .reg_addr_i(addr[3]),
    .reg_wdata_i(wd[3]), .reg_rdata_o(rd[3]), .clk_div_o(dclk[3]), .autoidle_o(idle[3]));

  for (genvar k = 0; k < 4; k++) begin : g_mon
    always @(posedge dclk[k]) begin
      per[k]       = cyc - last_rise[k];
      last_rise[k] = cyc;
      rises[k]     = rises[k] + 1;
    end
    always @(negedge dclk[k]) hi[k] = cyc - last_rise[k];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int u, input bit a, input logic [31:0] d);
    @(negedge clk);
    wr[u] = 1'b1; addr[u] = a; wd[u] = d;
    @(negedge clk);
    wr[u] = 1'b0; addr[u] = 1'b0; wd[u] = '0;
  endtask

  task automatic rd_reg(input int u, input bit a, output logic [31:0] d);
    @(negedge clk);
    addr[u] = a;
    #1 d = rd[u];
    addr[u] = 1'b0;
  endtask

  // driver: push expectation, wait until the monitor has consumed it
  task automatic expect_per(input int u, input int prev, input int div, input string tag);
    exp_t it;
    it.u = u; it.prev = prev; it.div = div; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  // monitor: boundary period at old length, then three periods at the new one
  initial begin
    exp_t it;
    int   base;
    forever begin
      wait (exp_q.size() != 0);
      it   = exp_q[0];
      base = rises[it.u];
      wait (rises[it.u] > base);
      chk(per[it.u] == it.prev, {it.tag, " R8 boundary period"}, per[it.u], it.prev);
      for (int i = 0; i < 3; i++) begin
        base = rises[it.u];
        wait (rises[it.u] > base);
        chk(per[it.u] == it.div, {it.tag, " period"}, per[it.u], it.div);
        if (it.div >= 2)
          chk(hi[it.u] == it.div / 2, {it.tag, " R10 high time"}, hi[it.u], it.div / 2);
      end
      void'(exp_q.pop_front());
    end
  end

  function automatic int tbl_div(input int c);
    case (c)
      0: return 3; 1: return 0; 2: return 5; 3: return 2;
      4: return 0; 5: return 6; 6: return 1; default: return 9;
    endcase
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int          prev;
    for (int k = 0; k < 4; k++) begin
      wr[k] = 1'b0; addr[k] = 1'b0; wd[k] = '0;
      last_rise[k] = 0; per[k] = 0; hi[k] = 0; rises[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(0, 1'b0, v); chk(v == 32'h0, "reset ctrl R11", v, 0);
    rd_reg(0, 1'b1, v); chk(v == 32'h0, "reset status R6", v, 0);
    chk(idle[0] == 1'b0, "reset idle R9", idle[0], 0);
    rd_reg(1, 1'b0, v); chk(v == 32'h120, "reset ctrl dir R11", v, 32'h120);
    chk(idle[1] == 1'b0, "reset idle inv R9", idle[1], 0);
    expect_per(0, 1, 1, "reset R10");
    expect_per(3, 3, 3, "reset tbl R4");

    // R1 plus-one: every legal code
    prev = 1;
    for (int c = 0; c < 12; c++) begin
      wr_reg(0, 1'b0, 32'(c));
      expect_per(0, prev, c + 1, "R1 code");
      prev = c + 1;
    end
    // R5/R6 above max refused
    wr_reg(0, 1'b0, 32'd12);
    expect_per(0, 12, 12, "R5 above max");
    rd_reg(0, 1'b0, v); chk(v == 32'd11, "R6 field kept", v, 11);
    rd_reg(0, 1'b1, v); chk(v[0] == 1'b1, "R6 error set", v[0], 1);
    wr_reg(0, 1'b1, 32'h0);
    rd_reg(0, 1'b1, v); chk(v[0] == 1'b1, "R6 error sticky", v[0], 1);
    wr_reg(0, 1'b1, 32'h1);
    rd_reg(0, 1'b1, v); chk(v[0] == 1'b0, "R6 error cleared", v[0], 0);
    // R9 idle, R11 other bits
    wr_reg(0, 1'b0, 32'h8000_0003);
    chk(idle[0] == 1'b1, "R9 idle on", idle[0], 1);
    expect_per(0, 12, 4, "R9 code");
    wr_reg(0, 1'b0, 32'h0FF0_0005);
    chk(idle[0] == 1'b0, "R9 idle off", idle[0], 0);
    rd_reg(0, 1'b0, v); chk(v == 32'h0FF0_0005, "R11 readback", v, 32'h0FF0_0005);
    expect_per(0, 4, 6, "R11 other bits");

    // R7 commit, R2 direct
    wr_reg(1, 1'b0, 32'h0000_0520);
    expect_per(1, 1, 1, "R7 uncommitted");
    rd_reg(1, 1'b1, v); chk(v[1] == 1'b1, "R7 pending set", v[1], 1);
    rd_reg(1, 1'b0, v); chk(v == 32'h520, "R7 staged readback", v, 32'h520);
    wr_reg(1, 1'b0, 32'h0001_0520);
    expect_per(1, 1, 5, "R7 committed");
    rd_reg(1, 1'b1, v); chk(v[1] == 1'b0, "R7 pending clear", v[1], 0);
    rd_reg(1, 1'b0, v); chk(v == 32'h520, "R7 commit reads 0", v, 32'h520);
    prev = 5;
    for (int c = 1; c < 8; c++) begin
      wr_reg(1, 1'b0, 32'h0001_0020 | (32'(c) << 8));
      expect_per(1, prev, c, "R2 code");
      prev = c;
    end
    wr_reg(1, 1'b0, 32'h0001_0020);
    expect_per(1, 7, 7, "R2 code zero");
    rd_reg(1, 1'b1, v); chk(v[0] == 1'b1, "R2 zero error", v[0], 1);
    wr_reg(1, 1'b0, 32'h0000_0700);
    chk(idle[1] == 1'b1, "R9 inverted idle", idle[1], 1);

    // R3 power of two
    prev = 1;
    for (int c = 0; c < 5; c++) begin
      wr_reg(2, 1'b0, 32'(c) << 24);
      expect_per(2, prev, 1 << c, "R3 code");
      prev = 1 << c;
    end
    wr_reg(2, 1'b0, 32'd5 << 24);
    expect_per(2, 16, 16, "R5 pow2 above max");
    rd_reg(2, 1'b1, v); chk(v[0] == 1'b1, "R5 pow2 error", v[0], 1);

    // R4 table
    prev = 3;
    for (int c = 0; c < 8; c++) begin
      wr_reg(3, 1'b0, 32'h8000_0000 | (32'(c) << 4));
      if (tbl_div(c) != 0) begin
        expect_per(3, prev, tbl_div(c), "R4 code");
        prev = tbl_div(c);
      end else begin
        expect_per(3, prev, prev, "R4 zero entry");
        rd_reg(3, 1'b1, v); chk(v[0] == 1'b1, "R4 zero error", v[0], 1);
        wr_reg(3, 1'b1, 32'h1);
      end
    end

    finish_run();
  end
endmodule